// File: doc/BRIEF.md
# Prescaled 8-bit Reload Interval Timer

This block is an 8-bit interval timer that sits on a narrow 4-bit register bus. A prescaler divides the system clock by a power of two that software selects. Each prescaler output pulse advances an up-counter by one. When the counter passes its top value it reloads from an 8-bit reload register, and the block raises an overflow interrupt request.

Software loads the reload value in two nibble writes. The lower nibble is only staged. Writing the upper nibble commits both halves to the reload register and starts the counter from that value at once. The count is read back in two steps, upper nibble first. That first read freezes the lower nibble in a holding latch, so the two halves always belong to the same count.

Interrupt arbitration, clock source choice and the processor are outside the block. An enable flag for the interrupt arrives as an input.

Top module: `pscl_reload_timer`

## Requirements
- R1: After reset the following all read as zero: the counter, the staged low nibble, the reload register, the holding latch, the mode (code 000) and `ovfIrq`.
- R2: A write to address 0 stores `wrData` as the staged low nibble and does not change the counter.
- R3: A write to address 1 loads `{wrData, staged low nibble}` into both the counter and the reload register at that edge. If a prescaler pulse falls in the same cycle, the write wins and no overflow occurs.
- R4: A write to address 2 sets the mode from `wrData[2:0]` and clears the prescaler. Mode codes 0 to 7 select division by 2^11, 2^9, 2^7, 2^5, 2^3, 2^2, 2^1 and 2^0 in that order. Writes to address 3 change nothing.
- R5: While `clkEn` is low, neither the prescaler nor the counter advances. Counting resumes from the frozen prescaler phase.
- R6: With division 2^k and `clkEn` held high from a cleared prescaler, the counter advances once every 2^k cycles. A step from 0xFF loads the reload register instead of wrapping to zero.
- R7: `ovfIrq` is high for exactly the one cycle after each overflow edge, and only when `intEn` was high at that edge. With `intEn` low the counter still reloads.
- R8: With `rdSel` high, `rdData` shows the counter's upper nibble, and a cycle with `rdEn` high captures the lower nibble into the holding latch. With `rdSel` low, `rdData` shows the holding latch, not the live lower nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Clock enable for the prescaler and counter |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 low nibble, 1 high nibble, 2 mode |
| wrData | input | 4 | Write data |
| rdEn | input | 1 | Read strobe; with rdSel high it captures the low nibble |
| rdSel | input | 1 | Read select: 1 upper count nibble, 0 holding latch |
| rdData | output | 4 | Read data |
| intEn | input | 1 | Overflow interrupt enable |
| ovfIrq | output | 1 | One-cycle overflow interrupt request |

## Verification
Two functions can land on the same edge and collide. One is the upper-nibble write that commits a reload value. The other is a prescaler pulse that arrives while the counter sits at 0xFF. The bench sets up this collision by holding the counter at 0xFF at the fastest ratio and raising `clkEn` in the same cycle as the high write. It then expects no interrupt pulse, a count equal to the newly written value, and later a natural overflow that reloads that same value. A second, similar case reads the upper nibble in a cycle where the counter also steps, and checks that the later low read returns the nibble from before that step.

// File: rtl/pscl_timer_pkg.sv
package pscl_timer_pkg;
  localparam int NIB_W  = 4;
  localparam int CNT_W  = 2 * NIB_W;
  localparam int MODE_W = 3;
  localparam int PRE_W  = 11;
  localparam int ADDR_W = 2;
  localparam int SHIFT_W = $clog2(PRE_W + 1);

  localparam logic [ADDR_W-1:0] ADDR_LDLO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LDHI = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd2;

  typedef struct packed {
    logic tick;   // prescaler output pulse
    logic ldLo;   // stage low reload nibble
    logic ldHi;   // commit reload and load counter
    logic capLo;  // capture low count nibble into latch
  } tmrStrobe_t;

  // division exponent for each mode code
  function automatic logic [SHIFT_W-1:0] modeShift(input logic [MODE_W-1:0] code);
    case (code)
      3'd0: modeShift = SHIFT_W'(11);
      3'd1: modeShift = SHIFT_W'(9);
      3'd2: modeShift = SHIFT_W'(7);
      3'd3: modeShift = SHIFT_W'(5);
      3'd4: modeShift = SHIFT_W'(3);
      3'd5: modeShift = SHIFT_W'(2);
      3'd6: modeShift = SHIFT_W'(1);
      default: modeShift = SHIFT_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/pscl_timer_ctrl.sv
module pscl_timer_ctrl
  import pscl_timer_pkg::*;
#(
  parameter int P_PRE_W  = PRE_W,
  parameter int P_MODE_W = MODE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clkEn,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [P_MODE_W-1:0] modeData,
  input  logic                rdEn,
  input  logic                rdSel,
  output tmrStrobe_t          strb
);
  logic [P_MODE_W-1:0] modeQ;
  logic [P_PRE_W-1:0]  prescQ;
  logic [P_PRE_W-1:0]  divMask;
  logic                modeWr;
  logic                phaseHit;

  assign modeWr  = wrEn && (wrAddr == ADDR_MODE);
  assign divMask = (P_PRE_W'(1) << modeShift(modeQ)) - P_PRE_W'(1);
  assign phaseHit = &(prescQ | ~divMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      prescQ <= '0;
    end else begin
      if (modeWr) begin
        modeQ  <= modeData;
        prescQ <= '0;
      end else if (clkEn) begin
        prescQ <= prescQ + P_PRE_W'(1);
      end
    end
  end

  always_comb begin
    strb.tick  = clkEn && phaseHit && !modeWr;
    strb.ldLo  = wrEn && (wrAddr == ADDR_LDLO);
    strb.ldHi  = wrEn && (wrAddr == ADDR_LDHI);
    strb.capLo = rdEn && rdSel;
  end
endmodule

// File: rtl/pscl_timer_dp.sv
module pscl_timer_dp
  import pscl_timer_pkg::*;
#(
  parameter int P_NIB_W = NIB_W,
  localparam int LP_CNT_W = 2 * P_NIB_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strb,
  input  logic [P_NIB_W-1:0] wrData,
  input  logic               rdSel,
  input  logic               intEn,
  output logic [P_NIB_W-1:0] rdData,
  output logic               ovfIrq
);
  logic [LP_CNT_W-1:0] cntQ;
  logic [LP_CNT_W-1:0] reloadQ;
  logic [P_NIB_W-1:0]  stageLo;
  logic [P_NIB_W-1:0]  holdLo;
  logic                atTop;
  logic [LP_CNT_W-1:0] newLoad;

  assign atTop   = &cntQ;
  assign newLoad = {wrData, stageLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      reloadQ <= '0;
      stageLo <= '0;
      holdLo  <= '0;
      ovfIrq  <= 1'b0;
    end else begin
      if (strb.ldLo) stageLo <= wrData;
      if (strb.ldHi) begin
        cntQ    <= newLoad;
        reloadQ <= newLoad;
      end else if (strb.tick) begin
        cntQ <= atTop ? reloadQ : cntQ + LP_CNT_W'(1);
      end
      if (strb.capLo) holdLo <= cntQ[P_NIB_W-1:0];
      ovfIrq <= strb.tick && !strb.ldHi && atTop && intEn;
    end
  end

  assign rdData = rdSel ? cntQ[LP_CNT_W-1:P_NIB_W] : holdLo;
endmodule

// File: rtl/pscl_reload_timer.sv
module pscl_reload_timer
  import pscl_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [NIB_W-1:0]  wrData,
  input  logic              rdEn,
  input  logic              rdSel,
  output logic [NIB_W-1:0]  rdData,
  input  logic              intEn,
  output logic              ovfIrq
);
  tmrStrobe_t strb;

  pscl_timer_ctrl #(.P_PRE_W(PRE_W), .P_MODE_W(MODE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .modeData(wrData[MODE_W-1:0]), .rdEn(rdEn), .rdSel(rdSel), .strb(strb)
  );

  pscl_timer_dp #(.P_NIB_W(NIB_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdSel(rdSel),
    .intEn(intEn), .rdData(rdData), .ovfIrq(ovfIrq)
  );
endmodule

// File: rtl/pscl_timer_chk.sv
module pscl_timer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        clkEn,
  input logic        wrEn,
  input logic [1:0]  wrAddr,
  input logic [3:0]  wrData,
  input logic        rdEn,
  input logic        rdSel,
  input logic        intEn,
  input logic        ovfIrq,
  input logic [7:0]  cntQ,
  input logic [7:0]  reloadQ,
  input logic [3:0]  stageLo,
  input logic [3:0]  holdLo,
  input logic [10:0] prescQ
);
  // R2
  lo_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd0 && !clkEn) |=> ($stable(cntQ) && stageLo == $past(wrData)));

  // R3
  hi_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd1) |=> (cntQ == $past({wrData, stageLo}) && reloadQ == cntQ && !ovfIrq));

  // R4
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd2) |=> (prescQ == 11'd0));

  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && !(wrEn && (wrAddr == 2'd1 || wrAddr == 2'd2))) |=> ($stable(cntQ) && $stable(prescQ)));

  // R6
  reload_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> (cntQ == reloadQ));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> $past(intEn));

  // R8
  hold_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel) |=> (holdLo == $past(cntQ[3:0])));
endmodule

bind pscl_reload_timer pscl_timer_chk uChk (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .rdEn(rdEn), .rdSel(rdSel), .intEn(intEn), .ovfIrq(ovfIrq),
  .cntQ(uDp.cntQ), .reloadQ(uDp.reloadQ), .stageLo(uDp.stageLo),
  .holdLo(uDp.holdLo), .prescQ(uCtrl.prescQ)
);

// File: tb/tb_pscl_reload_timer.sv
`timescale 1ns/1ps
module tb_pscl_reload_timer;
  localparam real CLK_NS = 8.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 1'b0, wrEn = 1'b0, rdEn = 1'b0, rdSel = 1'b0, intEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [3:0] wrData = '0;
  logic [3:0] rdData;
  logic ovfIrq;

  int checks = 0;
  int fails = 0;
  int irqSeen;

  always #(CLK_NS / 2.0) clk = ~clk;

  pscl_reload_timer dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData),
    .intEn(intEn), .ovfIrq(ovfIrq)
  );

  // fields: mode[31:29] preload[28:21] cycles[20:5] intEn[4]
  localparam int NVEC = 8;
  localparam logic [31:0] VEC [NVEC] = '{
    {3'd7, 8'h10, 16'd20,   1'b1, 4'd0},
    {3'd6, 8'hF0, 16'd40,   1'b1, 4'd0},
    {3'd5, 8'hFA, 16'd50,   1'b1, 4'd0},
    {3'd4, 8'h80, 16'd100,  1'b1, 4'd0},
    {3'd3, 8'hFE, 16'd200,  1'b1, 4'd0},
    {3'd2, 8'hFF, 16'd600,  1'b1, 4'd0},
    {3'd1, 8'h00, 16'd1100, 1'b0, 4'd0},
    {3'd0, 8'hFC, 16'd9000, 1'b1, 4'd0}
  };

  function automatic int expShift(input logic [2:0] m);
    case (m)
      3'd0: return 11; 3'd1: return 9; 3'd2: return 7; 3'd3: return 5;
      3'd4: return 3;  3'd5: return 2; 3'd6: return 1; default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    clkEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ovfIrq) irqSeen++;
    end
    clkEn = 1'b0;
  endtask

  task automatic readCnt(output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; rdSel = 1'b1;
    #1 v[7:4] = rdData;
    @(negedge clk);
    rdEn = 1'b0; rdSel = 1'b0;
    #1 v[3:0] = rdData;
  endtask

  task automatic load(input logic [7:0] v);
    wr(2'd0, v[3:0]);
    wr(2'd1, v[7:4]);
  endtask

  initial begin : watchdog
    #(CLK_NS * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] expC;
    int expIrq;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readCnt(v);
    check("R1 count after reset", v, 8'h00);
    check("R1 irq after reset", ovfIrq, 0);
    // R1/R4 reset mode is code 000: divide by 2048
    irqSeen = 0;
    run(2047);
    readCnt(v);
    check("R1 mode 000 no step before 2048", v, 8'h00);
    run(1);
    readCnt(v);
    check("R1 mode 000 step at 2048", v, 8'h01);

    // vector walk: R4 R6 R7
    foreach (VEC[i]) begin
      logic [2:0] m = VEC[i][31:29];
      logic [7:0] pre = VEC[i][28:21];
      int n = int'(VEC[i][20:5]);
      logic ien = VEC[i][4];
      int ticks = n >> expShift(m);
      expC = pre; expIrq = 0;
      for (int t = 0; t < ticks; t++) begin
        if (expC == 8'hFF) begin expC = pre; if (ien) expIrq++; end
        else expC = expC + 8'd1;
      end
      wr(2'd2, {1'b0, m});
      load(pre);
      intEn = ien;
      irqSeen = 0;
      run(n);
      readCnt(v);
      check($sformatf("R4/R6 vector %0d count", i), v, expC);
      check($sformatf("R7 vector %0d irq pulses", i), irqSeen, expIrq);
    end

    // R2 low write alone keeps count; R4 address 3 ignored
    wr(2'd2, 4'd7);
    load(8'h5A);
    wr(2'd0, 4'h3);
    readCnt(v);
    check("R2 low write keeps count", v, 8'h5A);
    wr(2'd3, 4'h0);
    readCnt(v);
    check("R4 address 3 ignored (count)", v, 8'h5A);
    run(1);
    readCnt(v);
    check("R4 address 3 ignored (mode still /1)", v, 8'h5B);

    // R5 freeze keeps prescaler phase
    wr(2'd2, 4'd6);
    load(8'h40);
    run(1);
    repeat (6) @(negedge clk);
    readCnt(v);
    check("R5 frozen count", v, 8'h40);
    run(1);
    readCnt(v);
    check("R5 phase resumes", v, 8'h41);

    // R4 mode write clears prescaler
    wr(2'd2, 4'd5);
    load(8'h20);
    run(3);
    wr(2'd2, 4'd5);
    run(3);
    readCnt(v);
    check("R4 mode write clears prescaler", v, 8'h20);
    run(1);
    readCnt(v);
    check("R4 step after cleared phase", v, 8'h21);

    // R8 coherent read while counting
    wr(2'd2, 4'd7);
    load(8'h2E);
    @(negedge clk);
    clkEn = 1'b1; rdEn = 1'b1; rdSel = 1'b1;
    #1 check("R8 high nibble", rdData, 4'h2);
    @(negedge clk);
    clkEn = 1'b0; rdEn = 1'b0; rdSel = 1'b0;
    #1 check("R8 latched low nibble", rdData, 4'hE);
    readCnt(v);
    check("R8 count moved on", v, 8'h2F);

    // R3 high write collides with overflow pulse
    intEn = 1'b1;
    load(8'hFF);
    wr(2'd0, 4'h4);
    @(negedge clk);
    clkEn = 1'b1; wrEn = 1'b1; wrAddr = 2'd1; wrData = 4'h3;
    @(negedge clk);
    clkEn = 1'b0; wrEn = 1'b0;
    #1 check("R3 no irq on collision", ovfIrq, 0);
    readCnt(v);
    check("R3 write wins over tick", v, 8'h34);
    irqSeen = 0;
    run(8'hCC);
    readCnt(v);
    check("R3 committed reload value", v, 8'h34);
    check("R7 one pulse after reload", irqSeen, 1);

    // R7 pulse width: exactly one cycle
    load(8'hFE);
    run(2);
    #1 check("R7 pulse present", ovfIrq, 1);
    @(negedge clk);
    #1 check("R7 pulse ends", ovfIrq, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule